// File: doc/BRIEF.md
# Reset Conditioner with Output Safe-State Forcing

This block takes a raw reset pin that may rise slowly and cross the input threshold several times, and turns it into one clean internal reset of guaranteed minimum width. The raw pin is sampled by a two-stage synchronizer on the shared system clock. A hold counter then keeps the internal reset asserted until the synchronized pin has been inactive for `HOLD_CYCLES` consecutive clocks. If the pin goes active again during that count, the count starts over, so a rippling edge yields a single reset and not a train of short ones.

While the internal reset is asserted, the block puts every pad class into its safe state. Active-low outputs are held high. Active-high outputs and the latch strobe are held low. Bidirectional pins have their output enables removed, so they float. The block also holds a small per-port control state: a partition flag and a link-test enable. Reset presets these to reconnected and enabled, and outside reset they follow request strobes from the port logic.

Top module: `rst_conditioner`

## Requirements
- R1: A high level on `rst_raw_i` sampled at clock edge k makes `rst_int_o` high from edge k+2 onward (two synchronizer stages and one hold register).
- R2: Every assertion of `rst_int_o` lasts at least `HOLD_CYCLES` clock cycles, including one caused by a single-cycle raw pulse.
- R3: If `rst_raw_i` is first sampled low at edge k and stays low, `rst_int_o` is still high after edge k+`HOLD_CYCLES` and low after edge k+`HOLD_CYCLES`+1.
- R4: A raw high sample taken while the hold count is running restarts the count. A ripple whose low gaps are shorter than `HOLD_CYCLES` produces exactly one rising edge on `rst_int_o`.
- R5: While `rst_int_o` is high, every bit of `pad_lo_o` is 1, and every bit of `pad_hi_o` and `pad_strobe_o` is 0, whatever the functional inputs are.
- R6: While `rst_int_o` is high, every bit of `pad_oe_o` is 0, so all bidirectional pins are released.
- R7: A clock edge that sees `rst_int_o` high sets every bit of `part_state_o` to 0 (reconnected) and every bit of `lt_en_o` to 1 (link test enabled). Port requests have no effect during reset.
- R8: Outside reset, bit i of `part_state_o` goes to 1 on an edge with `part_set_i[i]` high. It goes to 0 on an edge with `part_clr_i[i]` high and `part_set_i[i]` low, so set wins. Bit i of `lt_en_o` goes to 0 on an edge with `lt_dis_i[i]` high and stays 0 until the next reset.
- R9: Outside reset, the four pad outputs equal their functional inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common system clock |
| rst_raw_i | input | 1 | Raw reset pin, active high, possibly rippling |
| func_lo_i | input | LO_W | Functional values for active-low outputs |
| func_hi_i | input | HI_W | Functional values for active-high outputs |
| func_strobe_i | input | 1 | Functional latch strobe value |
| func_oe_i | input | BD_W | Functional output enables for bidirectional pins |
| part_set_i | input | PORTS | Per-port partition request |
| part_clr_i | input | PORTS | Per-port reconnect request |
| lt_dis_i | input | PORTS | Per-port link-test disable request |
| rst_int_o | output | 1 | Conditioned internal reset, active high |
| pad_lo_o | output | LO_W | Active-low outputs after safe-state forcing |
| pad_hi_o | output | HI_W | Active-high outputs after safe-state forcing |
| pad_strobe_o | output | 1 | Latch strobe after safe-state forcing |
| pad_oe_o | output | BD_W | Bidirectional output enables after forcing |
| part_state_o | output | PORTS | Per-port partition flag, 1 = partitioned |
| lt_en_o | output | PORTS | Per-port link-test enable |

## Verification
The assertions check the following on every cycle:
- the three-cycle assertion latency;
- the minimum high width;
- that each release follows a long enough quiet run on the raw pin;
- the forced pad levels and released enables during reset;
- the port preset on the edge after any reset cycle.

Only the bench scenarios can show the exact release edge. They can also show that a rippling pin gives one reset rather than several, that the set-over-clear priority holds, that link test stays disabled until reset, and that pads pass through unchanged once reset ends.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // Hold phases; the all-zero code is a reset phase so a zero power-up starts held.
    typedef enum logic [1:0] {
        PH_HELD  = 2'd0,
        PH_DRAIN = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // Pad classes, each with its own safe level.
    typedef enum logic [1:0] {
        CLS_ACT_LO = 2'd0,
        CLS_ACT_HI = 2'd1,
        CLS_STROBE = 2'd2,
        CLS_OE     = 2'd3
    } pad_cls_e;

    function automatic logic safe_level(input pad_cls_e cls);
        return (cls == CLS_ACT_LO);
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync (
    input  logic clk_i,
    input  logic in_i,
    output logic out_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.s1 = in_i;
        nxt_d.s2 = cur_q.s1;
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign out_o = cur_q.s2;
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk_i,
    input  logic in_sync_i,
    output logic rst_o
);
    import rstc_pkg::*;

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.phase)
            PH_RUN: begin
                if (in_sync_i) begin
                    nxt_d.phase = PH_HELD;
                    nxt_d.cnt   = '0;
                end
            end
            PH_HELD: begin
                if (!in_sync_i) begin
                    if (HOLD_CYCLES <= 1) begin
                        nxt_d.phase = PH_RUN;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.phase = PH_DRAIN;
                        nxt_d.cnt   = CW'(1);
                    end
                end
            end
            PH_DRAIN: begin
                if (in_sync_i) begin
                    nxt_d.phase = PH_HELD;
                    nxt_d.cnt   = '0;
                end else if (cur_q.cnt == LAST) begin
                    nxt_d.phase = PH_RUN;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            default: begin
                nxt_d.phase = PH_HELD;
                nxt_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign rst_o = (cur_q.phase != PH_RUN);
endmodule

// File: rtl/rstc_pin_force.sv
module rstc_pin_force #(
    parameter int                 W   = 4,
    parameter rstc_pkg::pad_cls_e CLS = rstc_pkg::CLS_ACT_HI
) (
    input  logic         rst_i,
    input  logic [W-1:0] func_i,
    output logic [W-1:0] pad_o
);
    localparam logic SAFE = rstc_pkg::safe_level(CLS);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (SAFE) begin : g_hi
            assign pad_o[i] = rst_i | func_i[i];
        end else begin : g_lo
            assign pad_o[i] = ~rst_i & func_i[i];
        end
    end
endmodule

// File: rtl/rstc_port_ctl.sv
module rstc_port_ctl #(
    parameter int PORTS = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [PORTS-1:0] set_i,
    input  logic [PORTS-1:0] clr_i,
    input  logic [PORTS-1:0] lt_dis_i,
    output logic [PORTS-1:0] part_o,
    output logic [PORTS-1:0] lt_en_o
);
    typedef struct packed {
        logic [PORTS-1:0] part;
        logic [PORTS-1:0] lt_en;
    } port_t;

    port_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (rst_i) begin
            nxt_d.part  = '0;
            nxt_d.lt_en = '1;
        end else begin
            nxt_d.part  = (cur_q.part | set_i) & ~(clr_i & ~set_i);
            nxt_d.lt_en = cur_q.lt_en & ~lt_dis_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign part_o  = cur_q.part;
    assign lt_en_o = cur_q.lt_en;
endmodule

// File: rtl/rst_conditioner.sv
module rst_conditioner #(
    parameter int HOLD_CYCLES = 16,
    parameter int LO_W        = 4,
    parameter int HI_W        = 4,
    parameter int BD_W        = 8,
    parameter int PORTS       = 8
) (
    input  logic             clk_i,
    input  logic             rst_raw_i,
    input  logic [LO_W-1:0]  func_lo_i,
    input  logic [HI_W-1:0]  func_hi_i,
    input  logic             func_strobe_i,
    input  logic [BD_W-1:0]  func_oe_i,
    input  logic [PORTS-1:0] part_set_i,
    input  logic [PORTS-1:0] part_clr_i,
    input  logic [PORTS-1:0] lt_dis_i,
    output logic             rst_int_o,
    output logic [LO_W-1:0]  pad_lo_o,
    output logic [HI_W-1:0]  pad_hi_o,
    output logic             pad_strobe_o,
    output logic [BD_W-1:0]  pad_oe_o,
    output logic [PORTS-1:0] part_state_o,
    output logic [PORTS-1:0] lt_en_o
);
    import rstc_pkg::*;

    logic raw_sync;
    logic rst_held;

    rstc_sync u_sync (
        .clk_i (clk_i),
        .in_i  (rst_raw_i),
        .out_o (raw_sync)
    );

    rstc_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk_i     (clk_i),
        .in_sync_i (raw_sync),
        .rst_o     (rst_held)
    );

    assign rst_int_o = rst_held;

    rstc_pin_force #(.W(LO_W), .CLS(CLS_ACT_LO)) u_force_lo (
        .rst_i (rst_held), .func_i (func_lo_i), .pad_o (pad_lo_o)
    );

    rstc_pin_force #(.W(HI_W), .CLS(CLS_ACT_HI)) u_force_hi (
        .rst_i (rst_held), .func_i (func_hi_i), .pad_o (pad_hi_o)
    );

    rstc_pin_force #(.W(1), .CLS(CLS_STROBE)) u_force_stb (
        .rst_i (rst_held), .func_i (func_strobe_i), .pad_o (pad_strobe_o)
    );

    rstc_pin_force #(.W(BD_W), .CLS(CLS_OE)) u_force_oe (
        .rst_i (rst_held), .func_i (func_oe_i), .pad_o (pad_oe_o)
    );

    rstc_port_ctl #(.PORTS(PORTS)) u_port (
        .clk_i    (clk_i),
        .rst_i    (rst_held),
        .set_i    (part_set_i),
        .clr_i    (part_clr_i),
        .lt_dis_i (lt_dis_i),
        .part_o   (part_state_o),
        .lt_en_o  (lt_en_o)
    );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int HOLD_CYCLES = 16,
    parameter int LO_W        = 4,
    parameter int HI_W        = 4,
    parameter int BD_W        = 8,
    parameter int PORTS       = 8
) (
    input logic             clk_i,
    input logic             rst_raw_i,
    input logic             rst_int_o,
    input logic [LO_W-1:0]  pad_lo_o,
    input logic [HI_W-1:0]  pad_hi_o,
    input logic             pad_strobe_o,
    input logic [BD_W-1:0]  pad_oe_o,
    input logic [PORTS-1:0] part_state_o,
    input logic [PORTS-1:0] lt_en_o
);
    localparam int KW = $clog2(HOLD_CYCLES + 3) + 1;
    localparam logic [KW-1:0] KMAX = '1;

    logic          armed_q = 1'b0;
    logic [KW-1:0] hi_cnt_q = '0;
    logic [KW-1:0] lo_cnt_q = '0;

    always_ff @(posedge clk_i) begin
        if (rst_int_o) armed_q <= 1'b1;
        hi_cnt_q <= !rst_int_o ? '0 : (hi_cnt_q == KMAX ? KMAX : hi_cnt_q + 1'b1);
        lo_cnt_q <= rst_raw_i ? '0 : (lo_cnt_q == KMAX ? KMAX : lo_cnt_q + 1'b1);
    end

    // R1: raw high three samples back means reset is already up
    p_latency_r1: assert property (@(posedge clk_i) disable iff (!armed_q)
        $past(rst_raw_i, 3) |-> rst_int_o);

    // R2: every reset pulse meets the minimum width
    p_min_width_r2: assert property (@(posedge clk_i) disable iff (!armed_q)
        $fell(rst_int_o) |-> (hi_cnt_q >= KW'(HOLD_CYCLES)));

    // R3: release only after a long enough quiet run on the raw pin
    p_quiet_release_r3: assert property (@(posedge clk_i) disable iff (!armed_q)
        $fell(rst_int_o) |-> (lo_cnt_q >= KW'(HOLD_CYCLES + 2)));

    // R5: safe levels per pad class
    p_safe_levels_r5: assert property (@(posedge clk_i) disable iff (!armed_q)
        rst_int_o |-> (pad_lo_o == '1 && pad_hi_o == '0 && !pad_strobe_o));

    // R6: bidirectional enables released
    p_oe_released_r6: assert property (@(posedge clk_i) disable iff (!armed_q)
        rst_int_o |-> (pad_oe_o == '0));

    // R7: port state preset after any reset edge
    p_port_preset_r7: assert property (@(posedge clk_i) disable iff (!armed_q)
        rst_int_o |=> (part_state_o == '0 && lt_en_o == '1));
endmodule

bind rst_conditioner rstc_checker #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .LO_W        (LO_W),
    .HI_W        (HI_W),
    .BD_W        (BD_W),
    .PORTS       (PORTS)
) u_chk (
    .clk_i        (clk_i),
    .rst_raw_i    (rst_raw_i),
    .rst_int_o    (rst_int_o),
    .pad_lo_o     (pad_lo_o),
    .pad_hi_o     (pad_hi_o),
    .pad_strobe_o (pad_strobe_o),
    .pad_oe_o     (pad_oe_o),
    .part_state_o (part_state_o),
    .lt_en_o      (lt_en_o)
);

// File: tb/rst_conditioner_test.sv
`timescale 1ns/1ps
module rst_conditioner_test;
    localparam int N  = 16;
    localparam int LW = 4;
    localparam int HW = 4;
    localparam int BW = 8;
    localparam int P  = 8;

    logic          clk = 1'b0;
    logic          raw = 1'b1;
    logic [LW-1:0] f_lo = '0;
    logic [HW-1:0] f_hi = '1;
    logic          f_stb = 1'b1;
    logic [BW-1:0] f_oe = '1;
    logic [P-1:0]  p_set = '0, p_clr = '0, p_ltd = '0;
    logic          rst_int, pad_stb;
    logic [LW-1:0] pad_lo;
    logic [HW-1:0] pad_hi;
    logic [BW-1:0] pad_oe;
    logic [P-1:0]  part, lten;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rst_conditioner #(.HOLD_CYCLES(N), .LO_W(LW), .HI_W(HW), .BD_W(BW), .PORTS(P)) uut (
        .clk_i (clk), .rst_raw_i (raw),
        .func_lo_i (f_lo), .func_hi_i (f_hi), .func_strobe_i (f_stb), .func_oe_i (f_oe),
        .part_set_i (p_set), .part_clr_i (p_clr), .lt_dis_i (p_ltd),
        .rst_int_o (rst_int), .pad_lo_o (pad_lo), .pad_hi_o (pad_hi),
        .pad_strobe_o (pad_stb), .pad_oe_o (pad_oe),
        .part_state_o (part), .lt_en_o (lten)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state;
        step(4);
        check(rst_int == 1'b1, "R1 reset up at start", 64'(rst_int), 64'd1);
        check(pad_lo == '1, "R5 active-low forced high", 64'(pad_lo), 64'hf);
        check(pad_hi == '0 && pad_stb == 1'b0, "R5 active-high and strobe forced low",
              64'({pad_hi, pad_stb}), 64'd0);
        check(pad_oe == '0, "R6 bidir enables released", 64'(pad_oe), 64'd0);
        check(part == '0 && lten == '1, "R7 port preset", 64'({part, lten}), 64'h00ff);
    endtask

    task automatic t_release;
        raw = 1'b0;
        step(N + 1);
        check(rst_int == 1'b1, "R3 still held one edge before release", 64'(rst_int), 64'd1);
        step(1);
        check(rst_int == 1'b0, "R3 released on schedule", 64'(rst_int), 64'd0);
    endtask

    task automatic t_passthru;
        f_lo = 4'ha; f_hi = 4'h6; f_stb = 1'b1; f_oe = 8'h3c;
        step(1);
        check({pad_lo, pad_hi, pad_stb, pad_oe} == {4'ha, 4'h6, 1'b1, 8'h3c},
              "R9 pads follow pattern A", 64'({pad_lo, pad_hi, pad_stb, pad_oe}),
              64'({4'ha, 4'h6, 1'b1, 8'h3c}));
        f_lo = 4'h5; f_hi = 4'h9; f_stb = 1'b0; f_oe = 8'hc3;
        step(1);
        check({pad_lo, pad_hi, pad_stb, pad_oe} == {4'h5, 4'h9, 1'b0, 8'hc3},
              "R9 pads follow pattern B", 64'({pad_lo, pad_hi, pad_stb, pad_oe}),
              64'({4'h5, 4'h9, 1'b0, 8'hc3}));
    endtask

    task automatic t_port_requests;
        p_set = 8'h05;
        step(1);
        check(part == 8'h05, "R8 partition set", 64'(part), 64'h05);
        p_set = 8'h00; p_clr = 8'h01;
        step(1);
        check(part == 8'h04, "R8 reconnect clear", 64'(part), 64'h04);
        p_set = 8'h10; p_clr = 8'h14;
        step(1);
        check(part == 8'h10, "R8 set wins over clear", 64'(part), 64'h10);
        p_set = 8'h00; p_clr = 8'h00; p_ltd = 8'h80;
        step(1);
        check(lten == 8'h7f, "R8 link test disabled", 64'(lten), 64'h7f);
        p_ltd = 8'h00;
        step(1);
        check(lten == 8'h7f, "R8 link test stays disabled", 64'(lten), 64'h7f);
    endtask

    task automatic t_pulse;
        step(N + 4);
        raw = 1'b1;
        step(1);
        raw = 1'b0;
        step(1);
        check(rst_int == 1'b0, "R1 not yet up after one stage", 64'(rst_int), 64'd0);
        step(1);
        check(rst_int == 1'b1, "R1 up after edge k+2", 64'(rst_int), 64'd1);
        step(N - 1);
        check(rst_int == 1'b1, "R2 held for full width", 64'(rst_int), 64'd1);
        step(1);
        check(rst_int == 1'b0, "R2 released after minimum width", 64'(rst_int), 64'd0);
    endtask

    task automatic t_ripple;
        logic [9:0] pat = 10'b0110010001; // bit i drives edge i
        int rises = 0;
        int mism  = 0;
        logic prev = 1'b0;
        step(N + 4);
        for (int i = 0; i < N + 13; i++) begin
            raw = (i < 10) ? pat[i] : 1'b0;
            step(1);
            if (rst_int != ((i >= 2) && (i <= N + 9))) mism++;
            if (rst_int && !prev) rises++;
            prev = rst_int;
        end
        check(mism == 0, "R4 ripple merged, release timed from last high", 64'(mism), 64'd0);
        check(rises == 1, "R4 exactly one reset from ripple", 64'(rises), 64'd1);
    endtask

    task automatic t_reset_ports;
        raw = 1'b1; p_set = '1; p_ltd = '1;
        f_lo = '0; f_hi = '1; f_stb = 1'b1; f_oe = '1;
        step(4);
        check(part == '0 && lten == '1, "R7 requests ignored in reset",
              64'({part, lten}), 64'h00ff);
        check(pad_lo == '1 && pad_hi == '0 && !pad_stb, "R5 forced during second reset",
              64'({pad_lo, pad_hi, pad_stb}), 64'h1e0);
        check(pad_oe == '0, "R6 released during second reset", 64'(pad_oe), 64'd0);
        p_set = '0; p_ltd = '0; raw = 1'b0;
        step(N + 3);
        check(rst_int == 1'b0 && part == '0 && lten == '1, "R7 preset held after release",
              64'({rst_int, part, lten}), 64'h00ff);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_release();
        t_passthru();
        t_port_requests();
        t_pulse();
        t_ripple();
        t_reset_ports();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule